// File: doc/BRIEF.md
# Serial Voice-Sample Port with Sync-Width Detection

This block moves one 8-bit voice sample in each direction per frame over a three-wire serial link: a bit clock, a frame sync and a data line in each direction. A faster system clock oversamples the bit clock, the frame sync and the receive line through a short synchronizer. Rising and falling edges of the bit clock therefore become single-cycle strobes inside one clock domain.

The port measures each frame-sync pulse by counting bit-clock falling edges seen while sync is high. A pulse seen on only one falling edge is "short". A pulse seen on two or more is "long". The measured kind of one pulse decides how the next frame is handled.

In long handling, the most significant bit goes out on the sync rising edge. Bits advance on rising edges and receive bits are taken on falling edges from the first one. In short handling, everything starts one bit later. The transmitter drives an output-enable for an external three-state pad. A power-down input silences the transmitter, and it stays silent for a programmable number of whole frames after power-down ends.

Top module: `pcm_sync_port`

## Requirements
- R1: A sync pulse sampled high on two or more consecutive bit-clock falling edges is classified long, and `sync_is_long` reads 1 once the pulse has ended.
- R2: A sync pulse sampled high on exactly one bit-clock falling edge is classified short, and `sync_is_long` reads 0 once the pulse has ended.
- R3: Each frame is handled according to the classification of the previous sync pulse. After reset the classification is short.
- R4: Short handling, transmit: the MSB appears on `tx_out` and `tx_oe` rises at the first bit-clock rising edge after the falling edge that saw sync. Each later rising edge presents the next bit, MSB first.
- R5: Short handling: `tx_oe` falls at the bit-clock falling edge in the middle of the eighth bit.
- R6: Long handling, transmit: the MSB appears and `tx_oe` rises at the sync rising edge. Each later bit-clock rising edge presents the next bit, MSB first.
- R7: Long handling: `tx_oe` stays high while sync is high or the word is still shifting. It falls once sync is low and the falling edge in the middle of the eighth bit has passed. This holds for any sync width, and the width may change from frame to frame.
- R8: Receive takes 8 bits MSB first on bit-clock falling edges. Long handling starts at the first falling edge of the frame. Short handling starts at the falling edge after the one that saw sync. `rx_valid` is a one-cycle pulse with the assembled byte on `rx_word`.
- R9: The transmit byte is captured at the sync rising edge. Changes on `tx_word` later in the frame do not alter the bits sent.
- R10: While `pdn` is high, `tx_oe` is low from the next system clock on.
- R11: After reset, and after `pdn` falls, the frames starting at the next QUIET_FRAMES (default 2) sync rising edges are not driven. The frame that follows is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk | input | 1 | External serial bit clock |
| frame_sync | input | 1 | External frame sync, one rising edge per frame |
| pdn | input | 1 | Power-down, silences the transmitter |
| tx_word | input | WORD_W | Byte to send in the next frame |
| rx_in | input | 1 | Serial receive data |
| tx_out | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Output enable for the external three-state pad |
| rx_word | output | WORD_W | Last byte received |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` is updated |
| sync_is_long | output | 1 | Classification of the most recently finished sync pulse |

## Verification
The edge assertions assume three things about the inputs. The frame sync and the receive line change only together with a bit-clock rising edge. Each bit-clock level lasts longer than the synchronizer depth plus one system clock. A frame is long enough for the word to finish before the next sync rising edge. The stimulus meets all three: every rising-edge update drives `bit_clk`, `frame_sync` and `rx_in` at once, and each bit-clock level is held for eight system clocks. Frames last sixteen bit clocks, and sync widths sweep from one to eleven bit clocks so that short and long handling alternate. `pdn` is asserted in the middle of one driven frame.

// File: rtl/pcm_sync_port_pkg.sv
package pcm_sync_port_pkg;

   typedef enum logic [2:0] {
      TXS_IDLE   = 3'd0,
      TXS_WAIT_F = 3'd1,
      TXS_WAIT_R = 3'd2,
      TXS_SHIFT  = 3'd3,
      TXS_HOLD   = 3'd4
   } tx_state_e;

   localparam int LANE_BCLK = 0;
   localparam int LANE_FS   = 1;
   localparam int LANE_RX   = 2;
   localparam int LANES     = 3;

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync
   import pcm_sync_port_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_clk,
   input  logic frame_sync,
   input  logic rx_in,
   output logic bclk_rise,
   output logic bclk_fall,
   output logic fs_lvl,
   output logic fs_rise,
   output logic rx_lvl
);

   logic [LANES-1:0] raw;
   logic [LANES-1:0] lvl;
   logic [1:0]       prev_q;

   assign raw[LANE_BCLK] = bit_clk;
   assign raw[LANE_FS]   = frame_sync;
   assign raw[LANE_RX]   = rx_in;

   if (SYNC_STAGES < 0) begin : g_chk_stages
      $error("SYNC_STAGES must not be negative");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign lvl = raw;
   end else begin : g_chain
      logic [SYNC_STAGES-1:0][LANES-1:0] pipe;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pipe <= '0;
         end else begin
            pipe[0] <= raw;
            for (int i = 1; i < SYNC_STAGES; i++) begin
               pipe[i] <= pipe[i-1];
            end
         end
      end
      assign lvl = pipe[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= {lvl[LANE_FS], lvl[LANE_BCLK]};
   end

   assign bclk_rise = lvl[LANE_BCLK] & ~prev_q[0];
   assign bclk_fall = ~lvl[LANE_BCLK] & prev_q[0];
   assign fs_lvl    = lvl[LANE_FS];
   assign fs_rise   = lvl[LANE_FS] & ~prev_q[1];
   assign rx_lvl    = lvl[LANE_RX];

endmodule

// File: rtl/pcm_fs_classify.sv
module pcm_fs_classify #(
   parameter int LONG_MIN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_fall,
   input  logic fs_lvl,
   output logic mode_long
);

   localparam int CNT_W = $clog2(LONG_MIN + 1);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] LONG_THR = CNT_W'(LONG_MIN);

   if (LONG_MIN < 2) begin : g_chk_min
      $error("LONG_MIN must be at least 2");
   end

   logic [CNT_W-1:0] hi_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_cnt    <= '0;
         mode_long <= 1'b0;
      end else if (bclk_fall) begin
         if (fs_lvl) begin
            if (hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + 1'b1;
         end else if (hi_cnt != '0) begin
            mode_long <= (hi_cnt >= LONG_THR);
            hi_cnt    <= '0;
         end
      end
   end

   AST_CLASS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !bclk_fall |=> $stable(mode_long)); // R3

endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser
   import pcm_sync_port_pkg::*;
#(
   parameter int WORD_W       = 8,
   parameter int QUIET_FRAMES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pdn,
   input  logic              frame_start,
   input  logic              next_long,
   input  logic              bclk_rise,
   input  logic              bclk_fall,
   input  logic              fs_lvl,
   input  logic [WORD_W-1:0] tx_word,
   output logic              tx_out,
   output logic              tx_oe
);

   localparam int SENT_W = $clog2(WORD_W + 1);
   localparam int QW     = $clog2(QUIET_FRAMES + 1);
   localparam logic [SENT_W-1:0] LAST_BIT = SENT_W'(WORD_W);
   localparam logic [QW-1:0]     Q_LOAD   = QW'(QUIET_FRAMES);

   if (WORD_W < 2) begin : g_chk_w
      $error("WORD_W must be at least 2");
   end
   if (QUIET_FRAMES < 1) begin : g_chk_q
      $error("QUIET_FRAMES must be at least 1");
   end

   tx_state_e         st;
   logic [WORD_W-1:0] sh;
   logic [SENT_W-1:0] sent;
   logic [QW-1:0]     quiet;
   logic              blank;
   logic              frm_long;
   logic              oe_q;
   logic              out_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= TXS_IDLE;
         sh       <= '0;
         sent     <= '0;
         quiet    <= Q_LOAD;
         blank    <= 1'b1;
         frm_long <= 1'b0;
         oe_q     <= 1'b0;
         out_q    <= 1'b0;
      end else if (pdn) begin
         st    <= TXS_IDLE;
         oe_q  <= 1'b0;
         quiet <= Q_LOAD;
      end else if (frame_start) begin
         sh       <= tx_word;
         frm_long <= next_long;
         blank    <= (quiet != '0);
         if (quiet != '0) quiet <= quiet - 1'b1;
         if (next_long) begin
            out_q <= tx_word[WORD_W-1];
            oe_q  <= (quiet == '0);
            sent  <= SENT_W'(1);
            st    <= TXS_SHIFT;
         end else begin
            oe_q <= 1'b0;
            st   <= TXS_WAIT_F;
         end
      end else begin
         case (st)
            TXS_WAIT_F: if (bclk_fall) st <= TXS_WAIT_R;
            TXS_WAIT_R: if (bclk_rise) begin
               out_q <= sh[WORD_W-1];
               oe_q  <= ~blank;
               sent  <= SENT_W'(1);
               st    <= TXS_SHIFT;
            end
            TXS_SHIFT: begin
               if (bclk_rise && sent != LAST_BIT) begin
                  sh    <= sh << 1;
                  out_q <= sh[WORD_W-2];
                  sent  <= sent + 1'b1;
               end else if (bclk_fall && sent == LAST_BIT) begin
                  if (frm_long && fs_lvl) begin
                     st <= TXS_HOLD;
                  end else begin
                     oe_q <= 1'b0;
                     st   <= TXS_IDLE;
                  end
               end
            end
            TXS_HOLD: if (!fs_lvl) begin
               oe_q <= 1'b0;
               st   <= TXS_IDLE;
            end
            default: st <= TXS_IDLE;
         endcase
      end
   end

   assign tx_out = out_q;
   assign tx_oe  = oe_q;

   AST_PDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      pdn |=> !oe_q); // R10
   AST_OE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> $past(bclk_rise)); // R4
   AST_OE_OFF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_q) |-> $past(bclk_fall || bclk_rise || pdn)); // R5
   AST_QUIET_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !pdn && quiet != '0) |=> !oe_q); // R11

endmodule

// File: rtl/pcm_rx_des.sv
module pcm_rx_des #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              next_long,
   input  logic              bclk_fall,
   input  logic              rx_lvl,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid
);

   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

   if (WORD_W < 2) begin : g_chk_w
      $error("WORD_W must be at least 2");
   end

   logic [WORD_W-1:0] rsh;
   logic [CNT_W-1:0]  cnt;
   logic              skip;
   logic              active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsh      <= '0;
         cnt      <= '0;
         skip     <= 1'b0;
         active   <= 1'b0;
         rx_word  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (frame_start) begin
            skip   <= ~next_long;
            cnt    <= '0;
            active <= 1'b1;
         end else if (bclk_fall && active) begin
            if (skip) begin
               skip <= 1'b0;
            end else begin
               rsh <= {rsh[WORD_W-2:0], rx_lvl};
               if (cnt == LAST_IDX) begin
                  rx_word  <= {rsh[WORD_W-2:0], rx_lvl};
                  rx_valid <= 1'b1;
                  active   <= 1'b0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end

   AST_RXV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid); // R8
   AST_RXV_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_valid) |-> $past(bclk_fall)); // R8

endmodule

// File: rtl/pcm_sync_port.sv
module pcm_sync_port #(
   parameter int WORD_W       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int QUIET_FRAMES = 2,
   parameter int LONG_MIN     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_clk,
   input  logic              frame_sync,
   input  logic              pdn,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              rx_in,
   output logic              tx_out,
   output logic              tx_oe,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid,
   output logic              sync_is_long
);

   logic bclk_rise;
   logic bclk_fall;
   logic fs_lvl;
   logic fs_rise;
   logic rx_lvl;

   pcm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_clk    (bit_clk),
      .frame_sync (frame_sync),
      .rx_in      (rx_in),
      .bclk_rise  (bclk_rise),
      .bclk_fall  (bclk_fall),
      .fs_lvl     (fs_lvl),
      .fs_rise    (fs_rise),
      .rx_lvl     (rx_lvl)
   );

   pcm_fs_classify #(.LONG_MIN(LONG_MIN)) u_class (
      .clk       (clk),
      .rst_n     (rst_n),
      .bclk_fall (bclk_fall),
      .fs_lvl    (fs_lvl),
      .mode_long (sync_is_long)
   );

   pcm_tx_ser #(.WORD_W(WORD_W), .QUIET_FRAMES(QUIET_FRAMES)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .pdn         (pdn),
      .frame_start (fs_rise),
      .next_long   (sync_is_long),
      .bclk_rise   (bclk_rise),
      .bclk_fall   (bclk_fall),
      .fs_lvl      (fs_lvl),
      .tx_word     (tx_word),
      .tx_out      (tx_out),
      .tx_oe       (tx_oe)
   );

   pcm_rx_des #(.WORD_W(WORD_W)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (fs_rise),
      .next_long   (sync_is_long),
      .bclk_fall   (bclk_fall),
      .rx_lvl      (rx_lvl),
      .rx_word     (rx_word),
      .rx_valid    (rx_valid)
   );

endmodule

// File: tb/pcm_sync_port_tb.sv
module pcm_sync_port_tb;

   localparam int H      = 8;
   localparam int NBIT   = 16;
   localparam int NFR    = 40;
   localparam int PD_FR  = 20;
   localparam int PD_BIT = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_clk = 1'b0;
   logic       frame_sync = 1'b0;
   logic       pdn = 1'b0;
   logic [7:0] tx_word = 8'h00;
   logic       rx_in = 1'b0;
   logic       tx_out;
   logic       tx_oe;
   logic [7:0] rx_word;
   logic       rx_valid;
   logic       sync_is_long;

   int checks = 0;
   int fails = 0;
   int nvalid = 0;
   logic [7:0] last_rx = 8'h00;
   bit done = 0;

   always #5 clk = ~clk;

   pcm_sync_port u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bit_clk      (bit_clk),
      .frame_sync   (frame_sync),
      .pdn          (pdn),
      .tx_word      (tx_word),
      .rx_in        (rx_in),
      .tx_out       (tx_out),
      .tx_oe        (tx_oe),
      .rx_word      (rx_word),
      .rx_valid     (rx_valid),
      .sync_is_long (sync_is_long)
   );

   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         nvalid  <= nvalid + 1;
         last_rx <= rx_word;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int width_of(input int j);
      return (j % 3 == 1) ? 1 : ((j * 5) % 11) + 1;
   endfunction

   // expected enable: hi=1 for the half after a rising edge
   function automatic bit exp_oe(input bit lng, input int w, input int k, input bit hi);
      if (lng) return hi ? (k < 8 || k < w) : (k < 7 || k < w);
      else     return hi ? (k >= 1 && k <= 8) : (k >= 1 && k <= 7);
   endfunction

   function automatic int exp_idx(input bit lng, input int k);
      int i;
      i = lng ? k : k - 1;
      if (i > 7) i = 7;
      if (i < 0) i = 0;
      return 7 - i;
   endfunction

   task automatic run_frame(input int j, input bit lng, input bit drive, input int pd_at);
      int w;
      logic [7:0] txb;
      logic [7:0] rxb;
      int nv0;
      bit killed;
      bit eo;
      string rq;
      w   = width_of(j);
      txb = 8'(j * 37 + 90);
      rxb = 8'(j * 53 + 17);
      nv0 = nvalid;
      killed = 0;
      tx_word = txb;
      for (int k = 0; k < NBIT; k++) begin
         bit_clk    = 1'b1;
         frame_sync = (k < w);
         if (lng) rx_in = (k < 8) ? rxb[7-k] : 1'b0;
         else     rx_in = (k >= 1 && k <= 8) ? rxb[8-k] : 1'b0;
         if (k == 2) tx_word = ~txb; // R9: late change must not matter
         repeat (H) @(negedge clk);
         eo = exp_oe(lng, w, k, 1'b1) && drive && !killed;
         rq = lng ? "R7" : "R4";
         if (!drive) rq = "R11";
         chk(tx_oe === eo, rq, int'(tx_oe), int'(eo));
         if (eo) begin
            rq = (k >= 3) ? "R9" : (lng ? "R6" : "R4");
            chk(tx_out === txb[exp_idx(lng, k)], rq, int'(tx_out), int'(txb[exp_idx(lng, k)]));
         end
         bit_clk = 1'b0;
         if (k == pd_at) begin
            pdn = 1'b1;
            killed = 1;
         end
         if (pd_at >= 0 && k == pd_at + 2) pdn = 1'b0;
         repeat (H) @(negedge clk);
         eo = exp_oe(lng, w, k, 1'b0) && drive && !killed;
         rq = lng ? "R7" : "R5";
         if (!drive) rq = "R11";
         if (killed && k == pd_at) rq = "R10";
         chk(tx_oe === eo, rq, int'(tx_oe), int'(eo));
         if (eo) begin
            rq = (k >= 3) ? "R9" : (lng ? "R6" : "R4");
            chk(tx_out === txb[exp_idx(lng, k)], rq, int'(tx_out), int'(txb[exp_idx(lng, k)]));
         end
      end
      chk(nvalid - nv0 == 1, "R8", nvalid - nv0, 1);
      chk(last_rx === rxb, "R8", int'(last_rx), int'(rxb));
      if (w >= 2) chk(sync_is_long === 1'b1, "R1", int'(sync_is_long), 1);
      else        chk(sync_is_long === 1'b0, "R2", int'(sync_is_long), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      int qcnt;
      bit lng;
      bit drive;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(tx_oe === 1'b0, "R11", int'(tx_oe), 0);
      chk(rx_valid === 1'b0, "R8", int'(rx_valid), 0);
      chk(sync_is_long === 1'b0, "R3", int'(sync_is_long), 0);
      qcnt = 2;
      for (int j = 0; j < NFR; j++) begin
         lng   = (j == 0) ? 1'b0 : (width_of(j - 1) >= 2); // R3
         drive = (qcnt == 0);
         if (qcnt > 0) qcnt--;
         run_frame(j, lng, drive, (j == PD_FR) ? PD_BIT : -1);
         if (j == PD_FR) qcnt = 2;
      end
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule